// File: doc/BRIEF.md
# Data-Processing ALU with Status Flags

This block executes the sixteen data-processing operations of a classic 4-bit-opcode integer instruction set. The two operands arrive already shifted. The block returns the result, a destination write-enable and the next status word. It keeps the status word in a register that loads on every valid instruction. N, Z, C and V sit in the four top bits of that word, and the lower bits pass through untouched unless the word is restored whole.

The status update follows one of four flag modes, chosen for each instruction. In HOLD the word keeps its value. In RESTORE the whole word is replaced by the saved copy. In LOGIC, N and Z come from the result, C comes from the shifter carry input and V is kept. In ARITH, N, Z, C and V all come from the adder. The test and compare operations always update flags. The other operations update flags only when the set-flags input is high. When set-flags is high and the destination is register 15, the saved status word is restored in place of the flag computation.

Top module: `dp_alu_core`

## Requirements
- R1: Opcodes 0x0, 0x1, 0xC, 0xD, 0xE and 0xF drive `result` with a AND b, a XOR b, a OR b, b, a AND NOT b and NOT b. Opcodes 0x8 and 0x9 drive a AND b and a XOR b.
- R2: Opcodes 0x4 (and 0xB) give a+b, and 0x5 gives a+b+C. Opcodes 0x2 (and 0xA) give a−b, and 0x3 gives b−a. Opcode 0x6 gives a−b−1+C and 0x7 gives b−a−1+C. C is status bit 29 of the current word, and all results are modulo 2^32.
- R3: This applies to a logical opcode (0,1,C,D,E,F) with set_flags=1 and rd_idx≠15. N (bit 31) is set from result bit 31, Z (bit 30) is set when the result is zero, C (bit 29) takes `shift_c`, and V (bit 28) is kept.
- R4: For opcodes 0x4, 0x5 and 0xB, C is the carry out of the full sum. V is bit 31 of (a^r)&(b^r).
- R5: For the subtract forms 0x2, 0x3, 0x6, 0x7 and 0xA, the operands are left/right: (a,b) for 0x2, 0x6 and 0xA, and (b,a) for 0x3 and 0x7. C is set when the subtrahend (right, plus 1−C for the with-carry forms) is no greater than left. V is bit 31 of (left^r)&(~right^r).
- R6: When set_flags=1, rd_idx=15 and the opcode is not 0x8–0xB, `stat_next` equals `saved_stat` in full.
- R7: Opcodes 0x8 and 0x9 always set N and Z from the result and C from `shift_c`, and they keep V. Opcodes 0xA and 0xB always update N, Z, C and V as in R5 and R4. This holds whatever set_flags and rd_idx are.
- R8: `rd_we` is high exactly when `valid` is high and the opcode is not in 0x8–0xB.
- R9: When set_flags=0 and the opcode is not in 0x8–0xB, `stat_next` equals `stat_q`.
- R10: A synchronous reset clears `stat_q` to zero. On a clock edge with `valid` high, `stat_q` loads `stat_next`. With `valid` low, `stat_q` holds.
- R11: In every flag mode except RESTORE, status bits 27..0 of `stat_next` equal those of `stat_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| valid | input | 1 | Instruction present this cycle |
| opcode | input | 4 | Operation code |
| set_flags | input | 1 | Request a status update |
| rd_idx | input | 4 | Destination register index |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second (shifted) operand |
| shift_c | input | 1 | Shifter carry out |
| saved_stat | input | 32 | Saved status word for restore |
| result | output | 32 | Operation result |
| rd_we | output | 1 | Destination write-enable |
| stat_next | output | 32 | Next status word (combinational) |
| stat_q | output | 32 | Current status word (registered) |

## Verification
A wrong flag-mode choice shows at `stat_next` in the same cycle as the instruction, and at `stat_q` one edge later. A corrupted status register shows one instruction later, through the carry it feeds into ADC, SBC and RSC results. The sweep preloads the status word through the restore path before each vector. That way every opcode runs with both old carry values and both shifter carry values, on both sides of the register-15 boundary, so a wrong mode or a wrong carry term shows on the first vector that reaches it.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
        OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
        OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
        OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
    } alu_op_e;

    typedef enum logic [1:0] {
        FM_HOLD    = 2'd0,
        FM_RESTORE = 2'd1,
        FM_LOGIC   = 2'd2,
        FM_ARITH   = 2'd3
    } flag_mode_e;

    // Flag positions counted down from the top of the status word.
    localparam int FLAG_N_OFS = 1;
    localparam int FLAG_Z_OFS = 2;
    localparam int FLAG_C_OFS = 3;
    localparam int FLAG_V_OFS = 4;

    function automatic logic op_is_compare(input logic [3:0] op);
        return op[3:2] == 2'b10;
    endfunction

    function automatic logic op_is_arith(input logic [3:0] op);
        return (op[3:2] == 2'b01) || (op[3:1] == 3'b001) || (op[3:1] == 3'b101);
    endfunction

endpackage

// File: rtl/dp_logic_unit.sv
module dp_logic_unit
    import dp_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [3:0]        op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] res
);

    always_comb begin
        unique case (alu_op_e'(op))
            OP_AND, OP_TST: res = a & b;
            OP_EOR, OP_TEQ: res = a ^ b;
            OP_ORR:         res = a | b;
            OP_MOV:         res = b;
            OP_BIC:         res = a & ~b;
            OP_MVN:         res = ~b;
            default:        res = a & b;
        endcase
    end

endmodule

// File: rtl/dp_arith_unit.sv
module dp_arith_unit
    import dp_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [3:0]        op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              carry_old,
    output logic [DATA_W-1:0] res,
    output logic              carry_out,
    output logic              ovf
);

    localparam int SUM_W = DATA_W + 1;

    logic [DATA_W-1:0] x_in;
    logic [DATA_W-1:0] y_in;
    logic              c_in;
    logic [SUM_W-1:0]  sum;

    // Subtraction as left + NOT right + carry; reverse forms swap sides.
    always_comb begin
        unique case (alu_op_e'(op))
            OP_ADD, OP_CMN: begin x_in = a; y_in = b;  c_in = 1'b0;      end
            OP_ADC:         begin x_in = a; y_in = b;  c_in = carry_old; end
            OP_SUB, OP_CMP: begin x_in = a; y_in = ~b; c_in = 1'b1;      end
            OP_RSB:         begin x_in = b; y_in = ~a; c_in = 1'b1;      end
            OP_SBC:         begin x_in = a; y_in = ~b; c_in = carry_old; end
            OP_RSC:         begin x_in = b; y_in = ~a; c_in = carry_old; end
            default:        begin x_in = a; y_in = b;  c_in = 1'b0;      end
        endcase
    end

    assign sum       = {1'b0, x_in} + {1'b0, y_in} + {{DATA_W{1'b0}}, c_in};
    assign res       = sum[DATA_W-1:0];
    assign carry_out = sum[DATA_W];
    assign ovf       = (x_in[DATA_W-1] ^ res[DATA_W-1]) & (y_in[DATA_W-1] ^ res[DATA_W-1]);

endmodule

// File: rtl/dp_flag_select.sv
module dp_flag_select
    import dp_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic [3:0]        op,
    input  logic              set_flags,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [DATA_W-1:0] logic_res,
    input  logic [DATA_W-1:0] arith_res,
    input  logic              arith_c,
    input  logic              arith_v,
    input  logic              shift_c,
    input  logic [DATA_W-1:0] stat_cur,
    input  logic [DATA_W-1:0] saved,
    output logic [DATA_W-1:0] stat_nxt
);

    localparam logic [IDX_W-1:0] PC_IDX = {IDX_W{1'b1}};
    localparam int BIT_N = DATA_W - FLAG_N_OFS;
    localparam int BIT_Z = DATA_W - FLAG_Z_OFS;
    localparam int BIT_C = DATA_W - FLAG_C_OFS;
    localparam int BIT_V = DATA_W - FLAG_V_OFS;

    flag_mode_e mode;

    always_comb begin
        if (op_is_compare(op)) begin
            mode = op[1] ? FM_ARITH : FM_LOGIC;
        end else if (!set_flags) begin
            mode = FM_HOLD;
        end else if (rd_idx == PC_IDX) begin
            mode = FM_RESTORE;
        end else if (op_is_arith(op)) begin
            mode = FM_ARITH;
        end else begin
            mode = FM_LOGIC;
        end
    end

    always_comb begin
        stat_nxt = stat_cur;
        unique case (mode)
            FM_HOLD:    stat_nxt = stat_cur;
            FM_RESTORE: stat_nxt = saved;
            FM_LOGIC: begin
                stat_nxt[BIT_N] = logic_res[DATA_W-1];
                stat_nxt[BIT_Z] = (logic_res == '0);
                stat_nxt[BIT_C] = shift_c;
            end
            FM_ARITH: begin
                stat_nxt[BIT_N] = arith_res[DATA_W-1];
                stat_nxt[BIT_Z] = (arith_res == '0);
                stat_nxt[BIT_C] = arith_c;
                stat_nxt[BIT_V] = arith_v;
            end
            default:    stat_nxt = stat_cur;
        endcase
    end

endmodule

// File: rtl/dp_alu_core.sv
module dp_alu_core
    import dp_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  logic [3:0]        opcode,
    input  logic              set_flags,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              shift_c,
    input  logic [DATA_W-1:0] saved_stat,
    output logic [DATA_W-1:0] result,
    output logic              rd_we,
    output logic [DATA_W-1:0] stat_next,
    output logic [DATA_W-1:0] stat_q
);

    localparam int BIT_C = DATA_W - FLAG_C_OFS;

    logic [DATA_W-1:0] logic_res;
    logic [DATA_W-1:0] arith_res;
    logic              arith_c;
    logic              arith_v;

    dp_logic_unit #(.DATA_W(DATA_W)) u_logic (
        .op  (opcode),
        .a   (op_a),
        .b   (op_b),
        .res (logic_res)
    );

    dp_arith_unit #(.DATA_W(DATA_W)) u_arith (
        .op        (opcode),
        .a         (op_a),
        .b         (op_b),
        .carry_old (stat_q[BIT_C]),
        .res       (arith_res),
        .carry_out (arith_c),
        .ovf       (arith_v)
    );

    dp_flag_select #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_flags (
        .op        (opcode),
        .set_flags (set_flags),
        .rd_idx    (rd_idx),
        .logic_res (logic_res),
        .arith_res (arith_res),
        .arith_c   (arith_c),
        .arith_v   (arith_v),
        .shift_c   (shift_c),
        .stat_cur  (stat_q),
        .saved     (saved_stat),
        .stat_nxt  (stat_next)
    );

    always_comb begin
        result = op_is_arith(opcode) ? arith_res : logic_res;
        rd_we  = valid && !op_is_compare(opcode);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else if (valid) begin
            stat_q <= stat_next;
        end
    end

endmodule

// File: rtl/dp_alu_checker.sv
module dp_alu_checker #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              valid,
    input logic [3:0]        opcode,
    input logic              set_flags,
    input logic [IDX_W-1:0]  rd_idx,
    input logic [DATA_W-1:0] saved_stat,
    input logic              rd_we,
    input logic [DATA_W-1:0] stat_next,
    input logic [DATA_W-1:0] stat_q
);

    localparam logic [IDX_W-1:0] PC_IDX = {IDX_W{1'b1}};
    localparam int LOW_W = DATA_W - 4;

    logic cmp_op;
    logic restore_case;
    assign cmp_op       = (opcode[3:2] == 2'b10);
    assign restore_case = !cmp_op && set_flags && (rd_idx == PC_IDX);

    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> stat_q == '0);

    assert_load_R10: assert property (@(posedge clk) disable iff (rst)
        (!rst && valid) |=> stat_q == $past(stat_next));

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!rst && !valid) |=> $stable(stat_q));

    assert_no_write_cmp_R8: assert property (@(posedge clk) disable iff (rst)
        cmp_op |-> !rd_we);

    assert_write_other_R8: assert property (@(posedge clk) disable iff (rst)
        (valid && !cmp_op) |-> rd_we);

    assert_restore_R6: assert property (@(posedge clk) disable iff (rst)
        restore_case |-> stat_next == saved_stat);

    assert_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (!cmp_op && !set_flags) |-> stat_next == stat_q);

    assert_low_bits_kept_R11: assert property (@(posedge clk) disable iff (rst)
        !restore_case |-> stat_next[LOW_W-1:0] == stat_q[LOW_W-1:0]);

endmodule

bind dp_alu_core dp_alu_checker #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .valid      (valid),
    .opcode     (opcode),
    .set_flags  (set_flags),
    .rd_idx     (rd_idx),
    .saved_stat (saved_stat),
    .rd_we      (rd_we),
    .stat_next  (stat_next),
    .stat_q     (stat_q)
);

// File: tb/sim_dp_alu_core.sv
module sim_dp_alu_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid = 1'b0;
    logic [3:0]  opcode = 4'h0;
    logic        set_flags = 1'b0;
    logic [3:0]  rd_idx = 4'h0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        shift_c = 1'b0;
    logic [31:0] saved_stat = '0;
    logic [31:0] result;
    logic        rd_we;
    logic [31:0] stat_next;
    logic [31:0] stat_q;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    dp_alu_core u0 (
        .clk(clk), .rst(rst), .valid(valid), .opcode(opcode),
        .set_flags(set_flags), .rd_idx(rd_idx), .op_a(op_a), .op_b(op_b),
        .shift_c(shift_c), .saved_stat(saved_stat), .result(result),
        .rd_we(rd_we), .stat_next(stat_next), .stat_q(stat_q)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Independent model of result and next status word.
    function automatic logic [31:0] model_res(input logic [3:0] op,
            input logic [31:0] a, input logic [31:0] b, input logic oc);
        case (op)
            4'h0, 4'h8: return a & b;
            4'h1, 4'h9: return a ^ b;
            4'h2, 4'hA: return a - b;
            4'h3:       return b - a;
            4'h4, 4'hB: return a + b;
            4'h5:       return a + b + {31'd0, oc};
            4'h6:       return a - b - 32'd1 + {31'd0, oc};
            4'h7:       return b - a - 32'd1 + {31'd0, oc};
            4'hC:       return a | b;
            4'hD:       return b;
            4'hE:       return a & ~b;
            default:    return ~b;
        endcase
    endfunction

    function automatic logic [31:0] model_stat(input logic [3:0] op, input logic s,
            input logic [3:0] rd, input logic [31:0] a, input logic [31:0] b,
            input logic sc, input logic [31:0] old, input logic [31:0] sv);
        logic [31:0] r;
        logic [31:0] nw;
        logic [31:0] l;
        logic [31:0] rt;
        longint unsigned la;
        longint unsigned lb;
        logic oc;
        bit cmp;
        bit logical;
        oc = old[29];
        r = model_res(op, a, b, oc);
        cmp = (op >= 4'h8 && op <= 4'hB);
        logical = (op <= 4'h1) || (op >= 4'hC) || (op == 4'h8) || (op == 4'h9);
        nw = old;
        if (!cmp && !s) return old;
        if (!cmp && rd == 4'hF) return sv;
        nw[31] = r[31];
        nw[30] = (r == 32'd0);
        if (logical) begin
            nw[29] = sc;
            return nw;
        end
        if (op == 4'h4 || op == 4'h5 || op == 4'hB) begin
            la = 64'(a) + 64'(b) + ((op == 4'h5) ? 64'(oc) : 64'd0);
            nw[29] = la[32];
            nw[28] = ((a ^ r) & (b ^ r)) >> 31 != 0;
        end else begin
            l  = (op == 4'h3 || op == 4'h7) ? b : a;
            rt = (op == 4'h3 || op == 4'h7) ? a : b;
            la = 64'(l);
            lb = 64'(rt);
            if (op == 4'h6 || op == 4'h7) lb = lb + 64'd1 - 64'(oc);
            nw[29] = (lb <= la);
            nw[28] = ((l ^ r) & (~rt ^ r)) >> 31 != 0;
        end
        return nw;
    endfunction

    function automatic string stat_tag(input logic [3:0] op, input logic s,
                                       input logic [3:0] rd);
        if (op >= 4'h8 && op <= 4'hB) return "R7";
        if (!s) return "R9";
        if (rd == 4'hF) return "R6";
        if (op <= 4'h1 || op >= 4'hC) return "R3";
        if (op == 4'h4 || op == 4'h5) return "R4";
        return "R5";
    endfunction

    task automatic preload(input logic [31:0] w);
        @(negedge clk);
        opcode = 4'hD; set_flags = 1'b1; rd_idx = 4'hF;
        saved_stat = w; valid = 1'b1;
    endtask

    task automatic run_vec(input logic [3:0] op, input logic s, input logic [3:0] rd,
                           input logic [31:0] a, input logic [31:0] b, input logic sc,
                           input logic [31:0] old);
        logic [31:0] sv;
        logic [31:0] er;
        logic [31:0] en;
        string tg;
        sv = 32'h9000_0F0F;
        preload(old);
        @(negedge clk);
        check(stat_q == old, "R6 preload", stat_q, old);
        opcode = op; set_flags = s; rd_idx = rd; op_a = a; op_b = b;
        shift_c = sc; saved_stat = sv; valid = 1'b1;
        #1;
        er = model_res(op, a, b, old[29]);
        en = model_stat(op, s, rd, a, b, sc, old, sv);
        tg = stat_tag(op, s, rd);
        if (op_is_arith_tb(op))
            check(result == er, "R2 result", result, er);
        else
            check(result == er, "R1 result", result, er);
        check(rd_we == !(op >= 4'h8 && op <= 4'hB), "R8 rd_we",
              {31'd0, rd_we}, {31'd0, !(op >= 4'h8 && op <= 4'hB)});
        check(stat_next == en, {tg, " stat_next"}, stat_next, en);
        @(negedge clk);
        valid = 1'b0;
        #1;
        check(stat_q == en, "R10 load", stat_q, en);
    endtask

    function automatic bit op_is_arith_tb(input logic [3:0] op);
        return (op >= 4'h2 && op <= 4'h7) || op == 4'hA || op == 4'hB;
    endfunction

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL R10 watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] av [6];
        logic [31:0] bv [6];
        logic [31:0] olds [2];
        logic [31:0] keep;
        av[0] = 32'h0000_0000; bv[0] = 32'h0000_0000;
        av[1] = 32'hFFFF_FFFF; bv[1] = 32'h0000_0001;
        av[2] = 32'h7FFF_FFFF; bv[2] = 32'h0000_0001;
        av[3] = 32'h8000_0000; bv[3] = 32'h8000_0000;
        av[4] = 32'h0000_0005; bv[4] = 32'h0000_0007;
        av[5] = 32'h1234_5678; bv[5] = 32'h0F0F_0F0F;
        olds[0] = 32'h40AB_CDEF;   // Z set, C clear
        olds[1] = 32'hB0AB_CDEF;   // N, C, V set

        // R10: reset state
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        check(stat_q == 32'd0, "R10 reset", stat_q, 32'd0);

        for (int op = 0; op < 16; op++)
            for (int s = 0; s < 2; s++)
                for (int rdp = 0; rdp < 2; rdp++)
                    for (int k = 0; k < 6; k++)
                        for (int sc = 0; sc < 2; sc++)
                            for (int o = 0; o < 2; o++)
                                run_vec(4'(op), 1'(s), rdp ? 4'hF : 4'h3,
                                        av[k], bv[k], 1'(sc), olds[o]);

        // R10: hold with valid low
        for (int o = 0; o < 2; o++) begin
            preload(olds[o]);
            @(negedge clk);
            keep = stat_q;
            opcode = 4'hA; set_flags = 1'b1; rd_idx = 4'h0;
            op_a = 32'd0; op_b = 32'd1; valid = 1'b0;
            @(negedge clk);
            #1;
            check(stat_q == keep, "R10 hold", stat_q, keep);
        end

        // R10: reset wins over valid
        @(negedge clk);
        rst = 1'b1; valid = 1'b1; opcode = 4'hD; set_flags = 1'b1;
        rd_idx = 4'hF; saved_stat = 32'hFFFF_FFFF;
        @(negedge clk);
        rst = 1'b0; valid = 1'b0;
        #1;
        check(stat_q == 32'd0, "R10 reset priority", stat_q, 32'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule